// File: doc/BRIEF.md
# Stereo Digital Attenuator with Mute and Zero Detect

This block is a per-channel gain stage for a stereo stream of 24-bit two's-complement audio samples. Each frame carries one left and one right sample, marked by a single-cycle valid strobe. Each channel is scaled by its own 14-bit unsigned linear volume word. The scaled pair appears one clock after the strobe, together with an output valid strobe.

Gain changes never jump. Each channel keeps an effective gain register that moves toward its target by a bounded step once per frame. The target is the channel's volume word, or zero while either the hardware mute pin or the soft-mute control bit is high. A phase control inverts both outputs, saturating where negation would overflow.

A silence watchdog counts consecutive frames in which both input samples are zero and raises a flag once that run exceeds the configured frame count. Any non-zero sample drops the flag at once and restarts the count.

Top module: `stereo_atten`

## Requirements
- R1: After reset, left_o, right_o, valid_o and zero_o are 0, and both effective gains start at full volume (16383), so the first frames pass at unity gain.
- R2: valid_o is high for exactly the one cycle after each cycle with valid_i high. left_o and right_o change only in that cycle and hold their value otherwise.
- R3: For an effective gain g below 16383, the output is floor(sample * g / 16384), an arithmetic shift right by 14 of the signed product. The gain used is the one in effect before the frame's own ramp step.
- R4: An effective gain of 16383 passes the sample unchanged, including full-scale values.
- R5: The left and right channels use independent volume words and independent gain registers.
- R6: On each valid frame, each effective gain moves toward its target by RAMP_STEP, or lands exactly on the target when closer than that. It never changes without a valid frame.
- R7: While mute_pin_i is high, the target of both channels is 0. Once both gains reach 0, both outputs are 0 for any input.
- R8: soft_mute_i high mutes both channels the same way as the pin. With both mute controls low, the gains ramp back to their volume words.
- R9: With invert_i high, each output is the negation of the scaled value, except that -8388608 becomes +8388607.
- R10: zero_o rises in the cycle after the valid strobe of the (ZERO_FRAMES+1)-th consecutive frame whose left and right samples are both zero, and it stays high while such frames continue.
- R11: A valid frame with a non-zero sample on either channel clears zero_o in the next cycle and restarts the silence count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Frame strobe, one cycle per stereo frame |
| left_i | input | 24 | Left input sample, two's complement |
| right_i | input | 24 | Right input sample, two's complement |
| vol_left_i | input | 14 | Left volume word, unsigned linear |
| vol_right_i | input | 14 | Right volume word, unsigned linear |
| mute_pin_i | input | 1 | Hardware mute, active high |
| soft_mute_i | input | 1 | Control-register mute bit, active high |
| invert_i | input | 1 | Output polarity inversion |
| valid_o | output | 1 | Output frame strobe |
| left_o | output | 24 | Scaled left sample |
| right_o | output | 24 | Scaled right sample |
| zero_o | output | 1 | Silence flag for both channels |

## Verification
The bench keeps the default 24-bit data, 14-bit gain and 1024-frame silence limit, and overrides RAMP_STEP to 1024. A full ramp between silence and full volume then takes 16 frames. Each ramp, its exact landing on an odd target, and the return from mute can all be checked frame by frame with a short run. The unchanged 1024-frame limit lets the bench check the exact frame on which zero_o rises, and check its restart after a single non-zero frame.

// File: rtl/stereo_atten_pkg.sv
`timescale 1ns/1ps
package stereo_atten_pkg;
  localparam int NUM_CH = 2;
  typedef enum int {CH_LEFT = 0, CH_RIGHT = 1} ch_e;
endpackage

// File: rtl/gain_ramp.sv
`timescale 1ns/1ps
module gain_ramp #(
  parameter int GAIN_W    = 14,
  parameter int RAMP_STEP = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [GAIN_W-1:0] target_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] STEP_V   = GAIN_W'(RAMP_STEP);
  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};

  logic [GAIN_W-1:0] gain_q, gain_d, up_gap, dn_gap;

  always_comb begin
    up_gap = target_i - gain_q;
    dn_gap = gain_q - target_i;
    gain_d = gain_q;
    if (gain_q < target_i)
      gain_d = (up_gap > STEP_V) ? gain_q + STEP_V : target_i;
    else if (gain_q > target_i)
      gain_d = (dn_gap > STEP_V) ? gain_q - STEP_V : target_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gain_q <= GAIN_MAX;
    else if (step_i) gain_q <= gain_d;
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/sample_scaler.sv
`timescale 1ns/1ps
module sample_scaler #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              invert_i,
  output logic [DATA_W-1:0] sample_o
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic signed [PROD_W-1:0] prod, shifted;
  logic [DATA_W-1:0] scaled, polar, out_q;

  always_comb begin
    prod    = PROD_W'($signed(sample_i)) * $signed({1'b0, gain_i});
    shifted = prod >>> GAIN_W;
    scaled  = (gain_i == GAIN_MAX) ? sample_i : shifted[DATA_W-1:0];
    if (!invert_i)               polar = scaled;
    else if (scaled == MOST_NEG) polar = MOST_POS;  // saturate, no wrap
    else                         polar = -scaled;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_q <= '0;
    else if (load_i) out_q <= polar;
  end

  assign sample_o = out_q;
endmodule

// File: rtl/silence_detect.sv
`timescale 1ns/1ps
module silence_detect #(
  parameter int DATA_W      = 24,
  parameter int ZERO_FRAMES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              zero_o
);
  localparam int CNT_W = $clog2(ZERO_FRAMES + 2);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ZERO_FRAMES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q;
  logic             quiet;

  assign quiet = (left_i == '0) && (right_i == '0);

  always_comb begin
    if (!quiet)              cnt_d = '0;
    else if (cnt_q < CNT_TOP) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (valid_i) begin
      cnt_q  <= cnt_d;
      flag_q <= (cnt_d == CNT_TOP);
    end
  end

  assign zero_o = flag_q;
endmodule

// File: rtl/stereo_atten.sv
`timescale 1ns/1ps
module stereo_atten
  import stereo_atten_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int GAIN_W      = 14,
  parameter int RAMP_STEP   = 64,
  parameter int ZERO_FRAMES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic [GAIN_W-1:0] vol_left_i,
  input  logic [GAIN_W-1:0] vol_right_i,
  input  logic              mute_pin_i,
  input  logic              soft_mute_i,
  input  logic              invert_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] smp_in  [NUM_CH];
  logic [DATA_W-1:0] smp_out [NUM_CH];
  logic [GAIN_W-1:0] vol_w   [NUM_CH];
  logic [GAIN_W-1:0] gain_w  [NUM_CH];
  logic              muted;
  logic              valid_q;

  assign smp_in[CH_LEFT]  = left_i;
  assign smp_in[CH_RIGHT] = right_i;
  assign vol_w[CH_LEFT]   = vol_left_i;
  assign vol_w[CH_RIGHT]  = vol_right_i;
  assign muted = mute_pin_i | soft_mute_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [GAIN_W-1:0] target;
    assign target = muted ? '0 : vol_w[c];

    gain_ramp #(.GAIN_W(GAIN_W), .RAMP_STEP(RAMP_STEP)) u_ramp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (valid_i),
      .target_i(target),
      .gain_o  (gain_w[c])
    );

    sample_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (valid_i),
      .sample_i(smp_in[c]),
      .gain_i  (gain_w[c]),
      .invert_i(invert_i),
      .sample_o(smp_out[c])
    );
  end

  silence_detect #(.DATA_W(DATA_W), .ZERO_FRAMES(ZERO_FRAMES)) u_zero (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .left_i (left_i),
    .right_i(right_i),
    .zero_o (zero_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;
  assign left_o  = smp_out[CH_LEFT];
  assign right_o = smp_out[CH_RIGHT];
endmodule

// File: rtl/stereo_atten_chk.sv
`timescale 1ns/1ps
module stereo_atten_chk #(
  parameter int DATA_W    = 24,
  parameter int GAIN_W    = 14,
  parameter int RAMP_STEP = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] left_i,
  input logic [DATA_W-1:0] right_i,
  input logic              invert_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] left_o,
  input logic [DATA_W-1:0] right_o,
  input logic              zero_o,
  input logic [GAIN_W-1:0] gain_l_i,
  input logic [GAIN_W-1:0] gain_r_i
);
  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};
  localparam int STEP_I = RAMP_STEP;

  logic [GAIN_W-1:0] prev_l_q;
  logic              seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_l_q <= GAIN_MAX;
      seen_q   <= 1'b0;
    end else begin
      prev_l_q <= gain_l_i;
      seen_q   <= 1'b1;
    end
  end

  int delta_l;
  always_comb delta_l = (gain_l_i > prev_l_q) ? int'(gain_l_i - prev_l_q)
                                              : int'(prev_l_q - gain_l_i);

  AST_VALID_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid_o missing");  // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("valid_o spurious");  // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(left_o) && $stable(right_o))) else $error("output moved");  // R2
  AST_GAIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(gain_l_i) && $stable(gain_r_i))) else $error("gain moved");  // R6
  AST_GAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (delta_l <= STEP_I)) else $error("gain step too large");  // R6
  AST_UNITY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && gain_l_i == GAIN_MAX && !invert_i) |=> (left_o == $past(left_i)))
    else $error("unity altered");  // R4
  AST_MUTED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && gain_r_i == '0) |=> (right_o == '0)) else $error("muted nonzero");  // R7
  AST_ZERO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (left_i != '0 || right_i != '0)) |=> !zero_o) else $error("zero flag held");  // R11
endmodule

bind stereo_atten stereo_atten_chk #(
  .DATA_W(DATA_W), .GAIN_W(GAIN_W), .RAMP_STEP(RAMP_STEP)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .left_i  (left_i),
  .right_i (right_i),
  .invert_i(invert_i),
  .valid_o (valid_o),
  .left_o  (left_o),
  .right_o (right_o),
  .zero_o  (zero_o),
  .gain_l_i(gain_w[0]),
  .gain_r_i(gain_w[1])
);

// File: tb/stereo_atten_tb.sv
`timescale 1ns/1ps
module stereo_atten_tb;
  localparam int DW = 24;
  localparam int GW = 14;
  localparam int STEP = 1024;
  localparam int ZF = 1024;
  localparam int GMAX = 16383;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [DW-1:0] lin = '0, rin = '0;
  logic [GW-1:0] vol_l = 14'h3fff, vol_r = 14'h3fff;
  logic mute_pin = 1'b0, soft_mute = 1'b0, inv = 1'b0;
  logic valid_o, zero_o;
  logic [DW-1:0] lout, rout;

  int total = 0;
  int bad = 0;
  int gl = GMAX;
  int gr = GMAX;

  always #4 clk = ~clk;

  stereo_atten #(.DATA_W(DW), .GAIN_W(GW), .RAMP_STEP(STEP), .ZERO_FRAMES(ZF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .left_i(lin), .right_i(rin),
    .vol_left_i(vol_l), .vol_right_i(vol_r), .mute_pin_i(mute_pin),
    .soft_mute_i(soft_mute), .invert_i(inv), .valid_o(valid_o),
    .left_o(lout), .right_o(rout), .zero_o(zero_o)
  );

  function automatic int scale(int s, int g, bit iv);
    longint p;
    if (g == GMAX) p = s;
    else p = (longint'(s) * g) >>> 14;
    if (iv) p = (p == -8388608) ? 8388607 : -p;
    return int'(p);
  endfunction

  function automatic int ramp(int g, int t);
    if (g < t) return (t - g > STEP) ? g + STEP : t;
    if (g > t) return (g - t > STEP) ? g - STEP : t;
    return g;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one frame: drive at negedge, output sampled at following negedge
  task automatic frame(int l, int r, string req);
    int el, er, tl, tr;
    lin = DW'(l); rin = DW'(r); valid = 1'b1;
    el = scale(l, gl, inv);
    er = scale(r, gr, inv);
    tl = (mute_pin || soft_mute) ? 0 : int'(vol_l);
    tr = (mute_pin || soft_mute) ? 0 : int'(vol_r);
    gl = ramp(gl, tl);
    gr = ramp(gr, tr);
    @(negedge clk);
    valid = 1'b0;
    check(valid_o === 1'b1, "R2", longint'(valid_o), 1);
    check($signed(lout) == el, {req, " left"}, longint'($signed(lout)), el);
    check($signed(rout) == er, {req, " right"}, longint'($signed(rout)), er);
  endtask

  task automatic t_reset();
    check(lout == '0 && rout == '0, "R1 outputs", longint'(lout), 0);
    check(valid_o == 1'b0 && zero_o == 1'b0, "R1 flags", longint'({valid_o, zero_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    frame(8388607, -8388608, "R1 R4 full scale");
    frame(-1234567, 7654321, "R4 unity");
  endtask

  task automatic t_hold();
    logic [DW-1:0] hl;
    hl = lout;
    lin = 24'h123456;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R2 idle valid", longint'(valid_o), 0);
    check(lout == hl, "R2 hold", longint'(lout), longint'(hl));
  endtask

  task automatic t_volume();
    vol_l = 14'd4097;
    vol_r = 14'd12000;
    for (int i = 0; i < 14; i++) frame(3000000 - i * 77, -5000001 + i * 13, "R3 R5 R6 ramp");
    check(gl == 4097, "R6 landing", gl, 4097);
    frame(-7, 5, "R3 floor small");
    frame(-8388608, 8388607, "R3 extremes");
    vol_l = 14'h3fff;
    for (int i = 0; i < 14; i++) frame(1000 + i, -1000 - i, "R6 ramp up");
    check(gl == GMAX, "R6 back to full", gl, GMAX);
  endtask

  task automatic t_mute_pin();
    mute_pin = 1'b1;
    for (int i = 0; i < 17; i++) frame(4000000, -4000000, "R7 ramp down");
    frame(8388607, -8388608, "R7 silent");
    check(lout == '0 && rout == '0, "R7 zero out", longint'(lout), 0);
    mute_pin = 1'b0;
    for (int i = 0; i < 17; i++) frame(2222222, -3333333, "R7 release");
  endtask

  task automatic t_soft_mute();
    soft_mute = 1'b1;
    for (int i = 0; i < 17; i++) frame(-6000000, 6000000, "R8 ramp down");
    check(lout == '0 && rout == '0, "R8 zero out", longint'(rout), 0);
    soft_mute = 1'b0;
    for (int i = 0; i < 17; i++) frame(6000000, -6000000, "R8 restore");
    check(gl == GMAX && gr == 12000, "R8 gains restored", gl, GMAX);
  endtask

  task automatic t_invert();
    vol_r = 14'h3fff;
    for (int i = 0; i < 5; i++) frame(1, 2, "R9 settle");
    inv = 1'b1;
    frame(-8388608, 8388607, "R9 saturate");
    check($signed(lout) == 8388607, "R9 most negative", longint'($signed(lout)), 8388607);
    frame(100, -100, "R9 negate");
    inv = 1'b0;
  endtask

  task automatic t_zero();
    frame(5, 0, "R11 seed");
    for (int i = 0; i < ZF; i++) frame(0, 0, "R10 quiet");
    check(zero_o == 1'b0, "R10 not yet", longint'(zero_o), 0);
    frame(0, 0, "R10 quiet");
    check(zero_o == 1'b1, "R10 raised", longint'(zero_o), 1);
    frame(0, 0, "R10 quiet");
    check(zero_o == 1'b1, "R10 held", longint'(zero_o), 1);
    frame(0, -1, "R11 break");
    check(zero_o == 1'b0, "R11 cleared", longint'(zero_o), 0);
    for (int i = 0; i < ZF; i++) frame(0, 0, "R11 quiet");
    check(zero_o == 1'b0, "R11 restart", longint'(zero_o), 0);
    frame(0, 0, "R11 quiet");
    check(zero_o == 1'b1, "R11 raised again", longint'(zero_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_hold();
    t_volume();
    t_mute_pin();
    t_soft_mute();
    t_invert();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule